// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the device side of a serial EEPROM. It runs entirely on a fast system clock. It oversamples chip select, serial clock, serial data in, the hold input and the write-protect input, and it works out the serial clock edges from those samples. Every transfer begins with an 8-bit instruction. The instruction can set or clear the write enable latch, read or write the status byte, stream bytes out of the array, or collect up to one page of bytes for programming. The host SPI master may idle the clock low (mode 0) or high (mode 3). In both modes the block samples on the rising edge and shifts out on the falling edge.

Array writes are gathered in a page buffer. They are committed only when chip select is released cleanly on a byte boundary. Two block-protect bits fence off the top quarter, the top half or all of the array, and protected bytes are dropped without any indication. After each committed array write or status write, the block reports busy for a fixed number of clocks. This stands in for the self-timed programming cycle. While busy, the block answers only status reads.

Top module: `spi_eeprom_slave`

## Requirements
- R1: An instruction is recognised only when its upper nibble is zero. Bit 3 is ignored. Bits [2:0] select the operation: 110 latch set, 100 latch clear, 101 status read, 001 status write, 011 array read, 010 array write. Any other byte is ignored until chip select goes high.
- R2: In both clock idle levels, input bits are taken MSB first on rising edges and output bits change on falling edges. `so_en` is high only during the data phase of an array read or a status read.
- R3: The write enable latch is status bit 1. The set instruction sets it and the clear instruction clears it. It is also cleared at reset and at the end of every busy period.
- R4: An array write or status write instruction is rejected when the latch is clear or `wp_n` is low at the end of the instruction byte. A rejected instruction leaves the array, the status byte and the latch unchanged.
- R5: An array write carries a 16-bit address, MSB first, followed by 1 to 64 data bytes. The low 6 address bits wrap inside the page. The page is committed only if chip select rises with at least one complete data byte received and no partial byte. In every other case, nothing is written and no busy period starts.
- R6: Status bits [3:2] select the protected region: 00 none, 01 the top quarter, 10 the top half, 11 the whole array. A committed page leaves protected bytes unchanged and writes all the other bytes it carries.
- R7: Status bit 0 is high for `BUSY_CYCLES` clocks after each commit. During that time, every instruction except the status read is ignored, and an ignored read drives nothing.
- R8: An array read takes a 16-bit address, of which the low bits index the array. Each further byte comes from the next address, and the address wraps from the last location to zero.
- R9: A status read returns the byte {0000, protect bits, latch, busy} and keeps resending it while clocked.
- R10: While `hold_n` is low, clock edges are ignored and `so_en` is low. When hold is released, the transfer resumes from the bit it had reached.
- R11: After reset, the status byte reads zero, every array byte reads zero and `so_en` is low.
- R12: A committed status write changes only the protect bits, using data bits [3:2]. Status bits [7:4] always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data from the master |
| hold_n | input | 1 | Pause input, active low |
| wp_n | input | 1 | Write-protect input, active low |
| so | output | 1 | Serial data to the master |
| so_en | output | 1 | High when `so` should be driven |

## Verification
Damage to the internal state does not stay hidden for long. A corrupted latch or corrupted protect bits appear in the next status read, one instruction byte plus eight clock periods later. A bad page pointer, or a commit against the wrong protect bits, shows up as a wrong byte when that location is read back. A busy counter that stops early or runs too long changes how many status polls it takes to see busy clear, and it lets an instruction that should be ignored take effect. A bit counter that keeps moving during hold produces a shifted byte straight after the pause.

// File: rtl/ee_pkg.sv
// Shared types for the serial EEPROM slave: instruction kinds,
// transfer phases and the instruction decoder.
package ee_pkg;

    typedef enum logic [2:0] {
        OP_NONE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE
    } ee_op_e;

    typedef enum logic [2:0] {
        ST_CMD, ST_ADDR_HI, ST_ADDR_LO, ST_RD, ST_WR, ST_SR_RD, ST_SR_WR, ST_SKIP
    } ee_state_e;

    // Map an instruction byte to its kind; bit 3 is a don't-care.
    function automatic ee_op_e ee_decode(input logic [7:0] b);
        if (b[7:4] != 4'h0) return OP_NONE;
        case (b[2:0])
            3'b110:  return OP_WREN;
            3'b100:  return OP_WRDI;
            3'b101:  return OP_RDSR;
            3'b001:  return OP_WRSR;
            3'b011:  return OP_READ;
            3'b010:  return OP_WRITE;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ee_in_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Provides the synchronised level and the same level one clock older,
// so that callers can detect edges. Assumes every pin is slower than clk.
module ee_in_sync #(
    parameter int              WIDTH   = 5,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] prev
);
    logic [STAGES:0][WIDTH-1:0] pipe;

    // Shift the pin samples through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign level = pipe[STAGES-1];
    assign prev  = pipe[STAGES];
endmodule

// File: rtl/ee_spi_fsm.sv
// Serial protocol engine: detects clock edges, assembles input bytes,
// decodes instructions, tracks address phases and shifts read data out.
// Assumes inputs are already synchronised and SCK is much slower than clk.
module ee_spi_fsm
    import ee_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n_s,
    input  logic                     cs_n_p,
    input  logic                     sck_s,
    input  logic                     sck_p,
    input  logic                     si_s,
    input  logic                     hold_n_s,
    input  logic                     wp_n_s,
    input  logic                     busy,
    input  logic                     wel,
    input  logic [7:0]               status,
    input  logic [7:0]               rd_data,
    output logic                     so_bit,
    output logic                     so_en,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic [ADDR_W-PAGE_W-1:0] page_addr,
    output logic                     set_wel,
    output logic                     clr_wel,
    output logic                     pb_clr,
    output logic                     pb_we,
    output logic [PAGE_W-1:0]        pb_idx,
    output logic [7:0]               pb_data,
    output logic                     commit_arr,
    output logic                     commit_sr,
    output logic [1:0]               sr_bits
);
    ee_state_e          state;
    ee_op_e             cur_op;
    ee_op_e             op;
    logic [2:0]         bit_cnt;
    logic [6:0]         rx;
    logic [7:0]         tx;
    logic [7:0]         addr_hi;
    logic [ADDR_W-1:0]  addr_q;
    logic [ADDR_W-1:0]  addr_new;
    logic [PAGE_W-1:0]  off_nxt;
    logic               got_q;
    logic [1:0]         sr_q;
    logic               selected, active, rise, fall, cs_rise;
    logic [7:0]         byte_in;
    logic               byte_done, write_ok;

    // Edge detection and byte assembly helpers.
    always_comb begin
        selected  = !cs_n_s;
        active    = selected && hold_n_s;
        rise      = active && sck_s && !sck_p;
        fall      = active && !sck_s && sck_p;
        cs_rise   = cs_n_s && !cs_n_p;
        byte_in   = {rx, si_s};
        byte_done = rise && (bit_cnt == 3'd7);
        op        = ee_decode(byte_in);
        addr_new  = ADDR_W'({addr_hi, byte_in});
        off_nxt   = addr_q[PAGE_W-1:0] + PAGE_W'(1);
        write_ok  = wel && wp_n_s;
    end

    // Strobes handed to the storage side.
    always_comb begin
        set_wel    = byte_done && state == ST_CMD && !busy && op == OP_WREN;
        clr_wel    = byte_done && state == ST_CMD && !busy && op == OP_WRDI;
        pb_clr     = byte_done && state == ST_ADDR_LO && cur_op == OP_WRITE;
        pb_we      = byte_done && state == ST_WR;
        pb_idx     = addr_q[PAGE_W-1:0];
        pb_data    = byte_in;
        commit_arr = cs_rise && state == ST_WR && bit_cnt == 3'd0 && got_q;
        commit_sr  = cs_rise && state == ST_SR_WR && bit_cnt == 3'd0 && got_q;
        sr_bits    = sr_q;
        rd_addr    = (state == ST_ADDR_LO) ? addr_new : addr_q;
        page_addr  = addr_q[ADDR_W-1:PAGE_W];
        so_bit     = tx[7];
        so_en      = active && (state == ST_RD || state == ST_SR_RD);
    end

    // Transfer phase, shift registers and address tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CMD;
            cur_op  <= OP_NONE;
            bit_cnt <= '0;
            rx      <= '0;
            tx      <= '0;
            addr_hi <= '0;
            addr_q  <= '0;
            got_q   <= 1'b0;
            sr_q    <= '0;
        end else if (!selected) begin
            state   <= ST_CMD;
            bit_cnt <= '0;
            got_q   <= 1'b0;
        end else begin
            if (rise) begin
                rx      <= byte_in[6:0];
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (fall && bit_cnt != 3'd0) tx <= {tx[6:0], 1'b0};
            if (byte_done) begin
                case (state)
                    ST_CMD: begin
                        cur_op <= op;
                        if (busy && op != OP_RDSR) state <= ST_SKIP;
                        else begin
                            case (op)
                                OP_RDSR:  begin state <= ST_SR_RD; tx <= status; end
                                OP_WRSR:  state <= write_ok ? ST_SR_WR : ST_SKIP;
                                OP_READ:  state <= ST_ADDR_HI;
                                OP_WRITE: state <= write_ok ? ST_ADDR_HI : ST_SKIP;
                                default:  state <= ST_SKIP;
                            endcase
                        end
                    end
                    ST_ADDR_HI: begin
                        addr_hi <= byte_in;
                        state   <= ST_ADDR_LO;
                    end
                    ST_ADDR_LO: begin
                        if (cur_op == OP_READ) begin
                            tx     <= rd_data;
                            addr_q <= addr_new + ADDR_W'(1);
                            state  <= ST_RD;
                        end else begin
                            addr_q <= addr_new;
                            state  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        tx     <= rd_data;
                        addr_q <= addr_q + ADDR_W'(1);
                    end
                    ST_WR: begin
                        addr_q <= {addr_q[ADDR_W-1:PAGE_W], off_nxt};
                        got_q  <= 1'b1;
                    end
                    ST_SR_RD: tx <= status;
                    ST_SR_WR: begin
                        sr_q  <= byte_in[3:2];
                        got_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: a held transfer keeps its bit position.
    assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !hold_n_s) |=> $stable(bit_cnt));

    // R7: while busy, a non-status instruction leads to the ignore phase.
    assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_done && state == ST_CMD && ee_decode(byte_in) != OP_RDSR)
        |=> state == ST_SKIP);
endmodule

// File: rtl/ee_store.sv
// Storage side: array, page buffer, protect bits, write enable latch
// and the busy timer that stands in for the programming cycle.
// Assumes commit strobes arrive only when the latch is set and not busy.
module ee_store #(
    parameter int DEPTH       = 1024,
    parameter int ADDR_W      = 10,
    parameter int PAGE_W      = 6,
    parameter int BUSY_CYCLES = 500
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [ADDR_W-PAGE_W-1:0] page_addr,
    input  logic                     set_wel,
    input  logic                     clr_wel,
    input  logic                     pb_clr,
    input  logic                     pb_we,
    input  logic [PAGE_W-1:0]        pb_idx,
    input  logic [7:0]               pb_data,
    input  logic                     commit_arr,
    input  logic                     commit_sr,
    input  logic [1:0]               sr_bits,
    output logic [7:0]               rd_data,
    output logic [7:0]               status,
    output logic                     busy,
    output logic                     wel
);
    localparam int PAGE  = 1 << PAGE_W;
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [7:0]            mem [DEPTH];
    logic [PAGE-1:0][7:0]  slot_data;
    logic [PAGE-1:0]       slot_vld;
    logic [1:0]            bp;
    logic [CNT_W-1:0]      cnt;

    // True when address a lies in the region fenced by protect code b.
    function automatic logic is_locked(input logic [ADDR_W-1:0] a, input logic [1:0] b);
        case (b)
            2'b00:   return 1'b0;
            2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
            2'b10:   return a[ADDR_W-1];
            default: return 1'b1;
        endcase
    endfunction

    // One page-buffer slot per byte of a page.
    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        logic [7:0] d_q;
        logic       v_q;
        // Capture the byte aimed at this slot and mark it pending.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (pb_clr) begin
                v_q <= 1'b0;
            end else if (pb_we && pb_idx == PAGE_W'(g)) begin
                d_q <= pb_data;
                v_q <= 1'b1;
            end
        end
        assign slot_data[g] = d_q;
        assign slot_vld[g]  = v_q;
    end

    // Clear the array at reset; on commit copy pending, unprotected slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (commit_arr) begin
            for (int i = 0; i < PAGE; i++) begin
                if (slot_vld[i] && !is_locked({page_addr, PAGE_W'(i)}, bp))
                    mem[{page_addr, PAGE_W'(i)}] <= slot_data[i];
            end
        end
    end

    // Latch, protect bits and busy timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            wel  <= 1'b0;
            bp   <= '0;
        end else begin
            if (set_wel) wel <= 1'b1;
            if (clr_wel) wel <= 1'b0;
            if (commit_sr) bp <= sr_bits;
            if (commit_arr || commit_sr) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == CNT_W'(BUSY_CYCLES - 1)) begin
                    busy <= 1'b0;
                    wel  <= 1'b0;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign status  = {4'b0000, bp, wel, busy};

    // R4: a commit only follows an accepted, enabled write.
    assert_commit_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_arr || commit_sr) |-> (wel && !busy));

    // R3: the latch is gone once the busy period ends.
    assert_wel_clear_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R7: the timer never passes its limit.
    assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < CNT_W'(BUSY_CYCLES)));

    // R7: busy starts only because of a commit.
    assert_busy_from_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit_arr || commit_sr));
endmodule

// File: rtl/spi_eeprom_slave.sv
// Top of the serial EEPROM slave: synchronises the pins, runs the
// protocol engine and the storage side. Assumes DEPTH is a power of two
// of at least four pages, with address width no larger than 16 bits.
module spi_eeprom_slave #(
    parameter int DEPTH       = 1024,
    parameter int PAGE_BYTES  = 64,
    parameter int BUSY_CYCLES = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_en
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic [4:0]               pin_s, pin_p;
    logic                     busy, wel;
    logic [7:0]               status, rd_data;
    logic [ADDR_W-1:0]        rd_addr;
    logic [ADDR_W-PAGE_W-1:0] page_addr;
    logic                     set_wel, clr_wel, pb_clr, pb_we, commit_arr, commit_sr;
    logic [PAGE_W-1:0]        pb_idx;
    logic [7:0]               pb_data;
    logic [1:0]               sr_bits;

    ee_in_sync #(
        .WIDTH  (5),
        .STAGES (SYNC_STAGES),
        .RST_VAL(5'b11001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({wp_n, hold_n, si, sck, cs_n}),
        .level(pin_s),
        .prev (pin_p)
    );

    ee_spi_fsm #(
        .ADDR_W(ADDR_W),
        .PAGE_W(PAGE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (pin_s[0]),
        .cs_n_p    (pin_p[0]),
        .sck_s     (pin_s[1]),
        .sck_p     (pin_p[1]),
        .si_s      (pin_s[2]),
        .hold_n_s  (pin_s[3]),
        .wp_n_s    (pin_s[4]),
        .busy      (busy),
        .wel       (wel),
        .status    (status),
        .rd_data   (rd_data),
        .so_bit    (so),
        .so_en     (so_en),
        .rd_addr   (rd_addr),
        .page_addr (page_addr),
        .set_wel   (set_wel),
        .clr_wel   (clr_wel),
        .pb_clr    (pb_clr),
        .pb_we     (pb_we),
        .pb_idx    (pb_idx),
        .pb_data   (pb_data),
        .commit_arr(commit_arr),
        .commit_sr (commit_sr),
        .sr_bits   (sr_bits)
    );

    ee_store #(
        .DEPTH      (DEPTH),
        .ADDR_W     (ADDR_W),
        .PAGE_W     (PAGE_W),
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rd_addr),
        .page_addr (page_addr),
        .set_wel   (set_wel),
        .clr_wel   (clr_wel),
        .pb_clr    (pb_clr),
        .pb_we     (pb_we),
        .pb_idx    (pb_idx),
        .pb_data   (pb_data),
        .commit_arr(commit_arr),
        .commit_sr (commit_sr),
        .sr_bits   (sr_bits),
        .rd_data   (rd_data),
        .status    (status),
        .busy      (busy),
        .wel       (wel)
    );
endmodule

// File: tb/spi_eeprom_slave_bench.sv
module spi_eeprom_slave_bench;
    localparam int DEPTH = 1024;
    localparam int BUSY  = 2000;
    localparam int HALF  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_en;
    logic mode3 = 1'b0;

    int n_tests = 0, n_fail = 0, quiet = 0, viol = 0;
    logic [7:0] model_mem [DEPTH];
    logic       m_wel = 1'b0;
    logic [1:0] m_bp = 2'b00;

    always #10 clk = ~clk;

    spi_eeprom_slave #(.DEPTH(DEPTH), .PAGE_BYTES(64), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2))
        u_spi_eeprom_slave (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
                            .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en));

    // Per-clock watch: no drive while deselected or held (R2, R10).
    always @(negedge clk) begin
        if (rst_n && (cs_n || !hold_n)) quiet = quiet + 1; else quiet = 0;
        if (quiet > 4 && so_en) viol = viol + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        sck = mode3; tick(4); cs_n = 1'b0; tick(HALF);
    endtask

    task automatic cs_end();
        sck = mode3; tick(HALF); cs_n = 1'b1; tick(HALF);
    endtask

    task automatic xbit(input logic b, output logic r, output logic d);
        sck = 1'b0; si = b; tick(HALF);
        r = so; d = so_en;
        sck = 1'b1; tick(HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic drv);
        logic d;
        drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xbit(tx[i], rx[i], d);
            drv = drv & d;
        end
    endtask

    task automatic cmd1(input logic [7:0] c);
        logic [7:0] r; logic d;
        cs_begin(); xfer(c, r, d); cs_end();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] r; logic d;
        cs_begin(); xfer(8'h05, r, d); xfer(8'h00, st, d); cs_end();
    endtask

    function automatic logic locked(input int a);
        case (m_bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= (DEPTH * 3) / 4;
            2'b10:   return a >= DEPTH / 2;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
        return 8'(seed + 8'(k * 13));
    endfunction

    task automatic wait_ready();
        logic [7:0] st;
        int tries = 0;
        rdsr(st);
        chk("R7 busy and latch shown after commit", {24'd0, st}, {24'd0, 4'b0, m_bp, 2'b11});
        while (st[0] && tries < 60) begin rdsr(st); tries++; end
        m_wel = 1'b0;
        chk("R3 latch cleared when busy ends", {24'd0, st}, {24'd0, 4'b0, m_bp, 2'b00});
    endtask

    task automatic write_bytes(input int addr, input int n, input logic [7:0] seed, input logic wait_done);
        logic [7:0] r; logic d; int a;
        logic acc;
        acc = m_wel && wp_n && n > 0;
        cs_begin();
        xfer(8'h02, r, d); xfer(8'(addr >> 8), r, d); xfer(8'(addr), r, d);
        for (int k = 0; k < n; k++) xfer(pat(seed, k), r, d);
        cs_end();
        if (acc) begin
            for (int k = 0; k < n; k++) begin
                a = (addr & ~63) | ((addr + k) & 63);
                if (!locked(a)) model_mem[a] = pat(seed, k);
            end
            if (wait_done) wait_ready();
        end
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r; logic d;
        logic acc;
        acc = m_wel && wp_n;
        cs_begin(); xfer(8'h01, r, d); xfer(v, r, d); cs_end();
        if (acc) begin m_bp = v[3:2]; wait_ready(); end
    endtask

    task automatic read_check(input string req, input int addr, input int n);
        logic [7:0] r; logic d;
        cs_begin();
        xfer(8'h03, r, d); xfer(8'(addr >> 8), r, d); xfer(8'(addr), r, d);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r, d);
            chk(req, {24'd0, r}, {24'd0, model_mem[(addr + k) % DEPTH]});
        end
        cs_end();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] st, r, b;
        logic d, hb;
        for (int i = 0; i < DEPTH; i++) model_mem[i] = 8'h00;
        tick(5); rst_n = 1'b1; tick(5);

        // R11: reset state
        chk("R11 so_en low after reset", {31'd0, so_en}, 32'd0);
        rdsr(st);
        chk("R11 status zero after reset", {24'd0, st}, 32'd0);
        read_check("R11 array zero after reset", 0, 2);

        // R1, R3: latch set/clear, don't-care bit 3, bad upper nibble
        cmd1(8'h06); rdsr(st); m_wel = 1'b1;
        chk("R3 latch set", {24'd0, st}, 32'h02);
        cmd1(8'h04); rdsr(st); m_wel = 1'b0;
        chk("R3 latch cleared by instruction", {24'd0, st}, 32'h00);
        cmd1(8'h0E); rdsr(st); m_wel = 1'b1;
        chk("R1 bit 3 ignored in set", {24'd0, st}, 32'h02);
        cmd1(8'h0C); cmd1(8'h16); rdsr(st); m_wel = 1'b0;
        chk("R1 nonzero upper nibble ignored", {24'd0, st}, 32'h00);

        // R9: status repeats
        cs_begin(); xfer(8'h05, r, d); xfer(8'h00, st, d); xfer(8'h00, b, d); cs_end();
        chk("R9 status repeated", {24'd0, b}, {24'd0, st});

        // R4: write without latch
        write_bytes(16, 1, 8'hA5, 1'b1);
        read_check("R4 write without latch ignored", 16, 1);

        // R5/R7: single byte write in mode 3, busy behaviour
        mode3 = 1'b1;
        cmd1(8'h06); m_wel = 1'b1;
        write_bytes(16, 1, 8'hA5, 1'b0);
        cmd1(8'h04);
        rdsr(st);
        chk("R7 clear instruction ignored while busy", {24'd0, st}, 32'h03);
        cs_begin(); xfer(8'h03, r, d); xfer(8'h00, r, d); xfer(8'h10, r, d); xfer(8'h00, r, d); cs_end();
        chk("R7 read ignored while busy", {31'd0, d}, 32'd0);
        wait_ready();
        read_check("R5 single byte written (mode 3)", 16, 1);

        // R5: page wrap inside page
        cmd1(8'h06); m_wel = 1'b1;
        write_bytes(62, 5, 8'h31, 1'b1);
        read_check("R5 page offset wraps", 62, 2);
        read_check("R5 page offset wraps", 0, 3);

        // R5: full page
        mode3 = 1'b0;
        cmd1(8'h06); m_wel = 1'b1;
        write_bytes(128, 64, 8'h5A, 1'b1);
        read_check("R5 full page written", 128, 64);

        // R5: partial byte abort and no-data write
        cmd1(8'h06); m_wel = 1'b1;
        cs_begin(); xfer(8'h02, r, d); xfer(8'h00, r, d); xfer(8'h80, r, d);
        xfer(8'hEE, r, d); xbit(1'b1, r[0], d); xbit(1'b0, r[0], d); cs_end();
        rdsr(st);
        chk("R5 partial byte aborts commit", {24'd0, st}, 32'h02);
        read_check("R5 aborted page unchanged", 128, 1);
        cs_begin(); xfer(8'h02, r, d); xfer(8'h00, r, d); xfer(8'h80, r, d); cs_end();
        rdsr(st);
        chk("R5 no data byte means no commit", {24'd0, st}, 32'h02);

        // R4: write-protect pin blocks writes
        wp_n = 1'b0;
        write_bytes(5, 1, 8'h77, 1'b1);
        wrsr(8'h0C);
        rdsr(st);
        chk("R4 wp_n low blocks status write", {24'd0, st}, 32'h02);
        read_check("R4 wp_n low blocks array write", 5, 1);
        wp_n = 1'b1;

        // R12, R6: status write bits, protect regions
        wrsr(8'hF7);
        rdsr(st);
        chk("R12 only protect bits stored", {24'd0, st}, 32'h04);
        cmd1(8'h06); m_wel = 1'b1; write_bytes(767, 1, 8'h11, 1'b1);
        cmd1(8'h06); m_wel = 1'b1; write_bytes(768, 1, 8'h22, 1'b1);
        read_check("R6 quarter boundary", 767, 2);
        cmd1(8'h06); m_wel = 1'b1; wrsr(8'h08);
        cmd1(8'h06); m_wel = 1'b1; write_bytes(511, 1, 8'h33, 1'b1);
        cmd1(8'h06); m_wel = 1'b1; write_bytes(512, 1, 8'h44, 1'b1);
        read_check("R6 half boundary", 511, 2);
        cmd1(8'h06); m_wel = 1'b1; wrsr(8'h0C);
        cmd1(8'h06); m_wel = 1'b1; write_bytes(0, 2, 8'h55, 1'b1);
        read_check("R6 whole array protected", 0, 2);
        cmd1(8'h06); m_wel = 1'b1; wrsr(8'h00);

        // R8: read wraps to zero
        read_check("R8 read address wraps", DEPTH - 2, 4);

        // R10: hold mid-byte, R2 mode 0 output
        cs_begin(); xfer(8'h03, r, d); xfer(8'h00, r, d); xfer(8'h82, r, d);
        for (int i = 7; i >= 5; i--) xbit(1'b0, b[i], hb);
        hold_n = 1'b0; tick(HALF);
        chk("R10 so_en low during hold", {31'd0, so_en}, 32'd0);
        sck = 1'b0; tick(3); sck = 1'b1; tick(3);
        hold_n = 1'b1; tick(HALF);
        for (int i = 4; i >= 0; i--) xbit(1'b0, b[i], hb);
        cs_end();
        chk("R10 byte intact across hold (R2 mode 0)", {24'd0, b}, {24'd0, model_mem[130]});

        chk("R2 R10 no drive while idle or held", viol, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule